// File: doc/BRIEF.md
# Fractional-N Main Divider Controller

This block divides a prescaled VCO clock by a programmable integer ratio N and, with a small fractional accumulator, stretches chosen divide cycles to N+1. The output is a fractional divider whose average ratio is N + NF/Q. Each divide cycle ends with a one-clock output pulse for the phase detector. On that same edge the accumulator adds the fractional step NF, modulo Q. Q is 5 or 8. When the addition wraps, the cycle that has just started counts N+1 clocks.

The accumulator value and a product of that value and an 8-bit compensation weight come out of the block. A compensation-current controller scales its correction current from them. Both values change only on the pulse edge. A strobe marks that edge.

New settings are captured into a staging register at any time. They take effect only at a divide-cycle boundary, so a cycle that is already running is never cut short or lengthened by a reload. A power control input clears the fractional state. When the main section powers up again, the divide count starts from the beginning, which keeps it aligned with the reference path.

Top module: `fracn_main_div`

## Requirements
- R1: After reset, `div_pulse`, `comp_strobe`, `frd_out`, `comp_out` and `nf_err` are all 0.
- R2: With NF = 0, `div_pulse` is high for exactly one clock. Consecutive pulses are exactly N clocks apart.
- R3: With `cfg_mod5` = 1 the modulus is 5. On every pulse the accumulator becomes (acc + NF) mod 5, and `frd_out` shows the new value. If that addition reached or passed 5, the interval to the next pulse is N+1; otherwise it is N. With NF = 2, starting from 0, the values are 2, 4, 1, 3, 0 and then repeat.
- R4: With `cfg_mod5` = 0 the modulus is 8. It follows the same wrap and N+1 rule as R3. With NF = 3 the values are 3, 6, 1, 4, 7, 2, 5, 0.
- R5: A `cfg_load` pulse stages N, NF, modulus and FDAC. While the main section is powered, the staged set takes effect only at the next pulse edge. The cycle that is running keeps its length, and `frd_out` does not change before that edge. On the edge where the new set applies, the accumulator restarts from 0 before adding the new NF. The following cycle uses the new N.
- R6: If the staged NF is greater than or equal to the modulus, it is replaced by modulus−1. `nf_err` reads 1 while such a set is active and 0 once a legal set is applied.
- R7: A staged N below 512 is treated as 512.
- R8: On each pulse edge, `comp_out` becomes `frd_out` × FDAC (11 bits). It holds that value until the next pulse edge. `comp_strobe` is high on the same clocks as `div_pulse`.
- R9: While `main_pwr` is sampled 0, no pulse is produced and `frd_out` and `comp_out` are 0. Staged settings are applied at once. After power-up, the first pulse comes N clocks after the last edge at which `main_pwr` was sampled 0. The accumulator starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled VCO clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_pwr | input | 1 | 1 = main section powered, 0 = powered down |
| cfg_load | input | 1 | One-clock strobe that stages the cfg_* values |
| cfg_ratio | input | 16 | Integer divide ratio N |
| cfg_frac | input | 3 | Fractional step NF |
| cfg_mod5 | input | 1 | Modulus select: 0 = 8, 1 = 5 |
| cfg_dac | input | 8 | Compensation weight FDAC |
| div_pulse | output | 1 | One-clock pulse at the end of each divide cycle |
| comp_strobe | output | 1 | Cycle-aligned strobe for the compensation controller |
| frd_out | output | 3 | Current accumulator value |
| comp_out | output | 11 | Registered product of accumulator value and FDAC |
| nf_err | output | 1 | Active setting had its NF saturated |

## Verification
The divider is run with NF = 0 to confirm plain integer division, then with NF = 2 at modulus 5 and NF = 3 at modulus 8. These runs separate the wrap point of each modulus and show which cycles receive the extra clock. An out-of-range NF under modulus 5 and an N below the legal minimum show the saturation and clamping paths, because the pulse spacing and accumulator trail differ from an unclamped setting. A reload issued just after a pulse shows whether the running cycle kept its old length and whether the accumulator restarted at the boundary. A long powered-down idle shows that no pulses are produced.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    localparam int unsigned DIV_W = 16;
    localparam int unsigned NF_W  = 3;
    localparam int unsigned DAC_W = 8;
    localparam int unsigned CNT_W = DIV_W + 1;
    localparam int unsigned CMP_W = NF_W + DAC_W;
    localparam int unsigned MIN_RATIO = 512;
    localparam int unsigned RST_RATIO = 512;
    localparam int unsigned Q_WIDE = 8;
    localparam int unsigned Q_NARROW = 5;

    typedef struct packed {
        logic [DIV_W-1:0] ratio;
        logic [NF_W-1:0]  frac;
        logic             mod5;
        logic [DAC_W-1:0] dac;
        logic             clip;
    } div_cfg_t;

    localparam div_cfg_t CFG_RESET = '{
        ratio: DIV_W'(RST_RATIO),
        frac:  '0,
        mod5:  1'b0,
        dac:   '0,
        clip:  1'b0
    };

    function automatic logic [NF_W:0] modulus(input logic sel5);
        return sel5 ? (NF_W+1)'(Q_NARROW) : (NF_W+1)'(Q_WIDE);
    endfunction
endpackage

// File: rtl/fracn_stage.sv
module fracn_stage
    import fracn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             take,
    input  logic [DIV_W-1:0] ratio_i,
    input  logic [NF_W-1:0]  frac_i,
    input  logic             mod5_i,
    input  logic [DAC_W-1:0] dac_i,
    output logic [DIV_W-1:0] next_ratio,
    output logic [NF_W-1:0]  next_frac,
    output logic             next_mod5,
    output logic [DAC_W-1:0] next_dac,
    output logic             restart,
    output logic             clip_o
);
    typedef struct packed {
        div_cfg_t staged;
        div_cfg_t active;
        logic     pend;
    } stage_t;

    stage_t   s_d, s_q;
    div_cfg_t clean;
    div_cfg_t sel;
    logic [NF_W:0] q_in;

    always_comb begin
        q_in        = modulus(mod5_i);
        clean.ratio = (ratio_i < DIV_W'(MIN_RATIO)) ? DIV_W'(MIN_RATIO) : ratio_i;
        clean.mod5  = mod5_i;
        clean.dac   = dac_i;
        if ({1'b0, frac_i} >= q_in) begin
            clean.frac = NF_W'(q_in - 1'b1);
            clean.clip = 1'b1;
        end else begin
            clean.frac = frac_i;
            clean.clip = 1'b0;
        end

        s_d = s_q;
        if (take && s_q.pend) begin
            s_d.active = s_q.staged;
            s_d.pend   = 1'b0;
        end
        if (load) begin
            s_d.staged = clean;
            s_d.pend   = 1'b1;
        end

        sel        = s_q.pend ? s_q.staged : s_q.active;
        next_ratio = sel.ratio;
        next_frac  = sel.frac;
        next_mod5  = sel.mod5;
        next_dac   = sel.dac;
        restart    = take && s_q.pend;
        clip_o     = s_q.active.clip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.staged <= CFG_RESET;
            s_q.active <= CFG_RESET;
            s_q.pend   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: a staged step never reaches its own modulus
    a_r6_staged_sat: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pend |-> ({1'b0, s_q.staged.frac} < modulus(s_q.staged.mod5)));
    // R7: the ratio in force never drops below the legal floor
    a_r7_ratio_floor: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active.ratio >= DIV_W'(MIN_RATIO));
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
    import fracn_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            step,
    input  logic            restart,
    input  logic [NF_W-1:0] frac,
    input  logic            mod5,
    output logic [NF_W-1:0] acc,
    output logic [NF_W-1:0] acc_nxt,
    output logic            carry
);
    logic [NF_W-1:0] acc_d, acc_q;
    logic [NF_W-1:0] base;
    logic [NF_W:0]   sum;
    logic [NF_W:0]   q;
    logic [NF_W:0]   folded;
    logic            wrap;

    always_comb begin
        q       = modulus(mod5);
        base    = restart ? '0 : acc_q;
        sum     = {1'b0, base} + {1'b0, frac};
        wrap    = (sum >= q);
        folded  = wrap ? (sum - q) : sum;
        acc_nxt = folded[NF_W-1:0];
        carry   = en && step && wrap;
        if (!en) begin
            acc_d = '0;
        end else if (step) begin
            acc_d = acc_nxt;
        end else begin
            acc_d = acc_q;
        end
        acc = acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R5: the accumulator moves only on a divide-cycle boundary
    a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step) |=> $stable(acc_q));
    // R9: powered down clears the fractional state
    a_r9_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (acc_q == '0));
    // R3: the value produced at a boundary stays below the modulus in use
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step) |-> ({1'b0, acc_nxt} < q));
endmodule

// File: rtl/fracn_counter.sv
module fracn_counter
    import fracn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] ratio,
    input  logic             carry,
    output logic             boundary,
    output logic             pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        boundary = en && (c_q.cnt == '0);
        c_d      = c_q;
        if (!en) begin
            c_d.cnt   = CNT_W'(ratio) - CNT_W'(1);
            c_d.pulse = 1'b0;
        end else if (c_q.cnt == '0) begin
            c_d.cnt   = CNT_W'(ratio) + CNT_W'(carry) - CNT_W'(1);
            c_d.pulse = 1'b1;
        end else begin
            c_d.cnt   = c_q.cnt - CNT_W'(1);
            c_d.pulse = 1'b0;
        end
        pulse = c_q.pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cnt   <= CNT_W'(RST_RATIO) - CNT_W'(1);
            c_q.pulse <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    // R2: the output pulse lasts a single clock
    a_r2_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.pulse |=> !c_q.pulse);
    // R9: no pulse follows a powered-down clock
    a_r9_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !c_q.pulse);
endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
    import fracn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_pwr,
    input  logic             cfg_load,
    input  logic [15:0]      cfg_ratio,
    input  logic [2:0]       cfg_frac,
    input  logic             cfg_mod5,
    input  logic [7:0]       cfg_dac,
    output logic             div_pulse,
    output logic             comp_strobe,
    output logic [2:0]       frd_out,
    output logic [10:0]      comp_out
    ,output logic            nf_err
);
    logic [DIV_W-1:0] nx_ratio;
    logic [NF_W-1:0]  nx_frac;
    logic             nx_mod5;
    logic [DAC_W-1:0] nx_dac;
    logic             restart;
    logic             clip;
    logic             boundary;
    logic             carry;
    logic             pulse;
    logic [NF_W-1:0]  acc;
    logic [NF_W-1:0]  acc_nxt;
    logic [CMP_W-1:0] comp_d, comp_q;

    fracn_stage u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .take       (boundary || !main_pwr),
        .ratio_i    (cfg_ratio),
        .frac_i     (cfg_frac),
        .mod5_i     (cfg_mod5),
        .dac_i      (cfg_dac),
        .next_ratio (nx_ratio),
        .next_frac  (nx_frac),
        .next_mod5  (nx_mod5),
        .next_dac   (nx_dac),
        .restart    (restart),
        .clip_o     (clip)
    );

    fracn_accum u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (main_pwr),
        .step    (boundary),
        .restart (restart),
        .frac    (nx_frac),
        .mod5    (nx_mod5),
        .acc     (acc),
        .acc_nxt (acc_nxt),
        .carry   (carry)
    );

    fracn_counter u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (main_pwr),
        .ratio    (nx_ratio),
        .carry    (carry),
        .boundary (boundary),
        .pulse    (pulse)
    );

    always_comb begin
        comp_d = comp_q;
        if (!main_pwr) begin
            comp_d = '0;
        end else if (boundary) begin
            comp_d = CMP_W'(acc_nxt) * CMP_W'(nx_dac);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comp_q <= '0;
        end else begin
            comp_q <= comp_d;
        end
    end

    assign div_pulse   = pulse;
    assign comp_strobe = pulse;
    assign frd_out     = acc;
    assign comp_out    = comp_q;
    assign nf_err      = clip;

    // R8: the compensation word holds between pulse edges while powered
    a_r8_comp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (main_pwr && $past(main_pwr) && !pulse) |-> $stable(comp_q));
    // R9: outputs read zero one clock into power-down
    a_r9_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pwr |=> (acc == '0 && comp_q == '0));
endmodule

// File: tb/fracn_main_div_test.sv
module fracn_main_div_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        main_pwr = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_ratio = '0;
    logic [2:0]  cfg_frac = '0;
    logic        cfg_mod5 = 1'b0;
    logic [7:0]  cfg_dac = '0;
    logic        div_pulse, comp_strobe, nf_err;
    logic [2:0]  frd_out;
    logic [10:0] comp_out;

    always #5 clk = ~clk;

    fracn_main_div uut (
        .clk(clk), .rst_n(rst_n), .main_pwr(main_pwr), .cfg_load(cfg_load),
        .cfg_ratio(cfg_ratio), .cfg_frac(cfg_frac), .cfg_mod5(cfg_mod5),
        .cfg_dac(cfg_dac), .div_pulse(div_pulse), .comp_strobe(comp_strobe),
        .frd_out(frd_out), .comp_out(comp_out), .nf_err(nf_err)
    );

    typedef struct {
        int unsigned ivl;
        int unsigned frd;
        int unsigned comp;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int unsigned n_tests = 0;
    int unsigned n_fail = 0;
    int unsigned pulses_seen = 0;
    int unsigned m_acc, m_len;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int unsigned qmod(input bit m5);
        return m5 ? 5 : 8;
    endfunction

    function automatic int unsigned sat_nf(input int unsigned nf, input bit m5);
        return (nf >= qmod(m5)) ? qmod(m5) - 1 : nf;
    endfunction

    function automatic int unsigned clamp_n(input int unsigned n);
        return (n < 512) ? 512 : n;
    endfunction

    // driver side: expected pulses from the requirement-level model
    task automatic push_steps(input int cnt, input int unsigned n, input int unsigned nf,
                              input bit m5, input int unsigned dac, input string tag);
        for (int i = 0; i < cnt; i++) begin
            exp_t e;
            int unsigned s;
            e.ivl = m_len;
            s = m_acc + nf;
            m_len = n;
            if (s >= qmod(m5)) begin
                s = s - qmod(m5);
                m_len = n + 1;
            end
            m_acc = s;
            e.frd = m_acc;
            e.comp = m_acc * dac;
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    task automatic push_apply(input int unsigned n, input int unsigned nf,
                              input int unsigned dac, input string tag);
        exp_t e;
        e.ivl = m_len;
        m_acc = nf;
        m_len = n;
        e.frd = m_acc;
        e.comp = m_acc * dac;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive_cfg(input int unsigned n, input int unsigned nf,
                             input bit m5, input int unsigned dac);
        @(posedge clk); #2;
        cfg_ratio = 16'(n); cfg_frac = 3'(nf); cfg_mod5 = m5; cfg_dac = 8'(dac);
        cfg_load = 1'b1;
        @(posedge clk); #2;
        cfg_load = 1'b0;
    endtask

    task automatic set_pwr(input bit v);
        @(posedge clk); #2;
        main_pwr = v;
    endtask

    task automatic run_phase(input int unsigned n, input int unsigned nf, input bit m5,
                             input int unsigned dac, input int cnt, input string tag,
                             input bit exp_err);
        int unsigned nn, ff;
        set_pwr(1'b0);
        drive_cfg(n, nf, m5, dac);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(frd_out == 0, "R9", "frd while off", frd_out, 0);
        chk(comp_out == 0, "R9", "comp while off", comp_out, 0);
        chk(nf_err == exp_err, "R6", {tag, " nf_err"}, nf_err, exp_err);
        nn = clamp_n(n);
        ff = sat_nf(nf, m5);
        m_acc = 0;
        m_len = nn;
        push_steps(cnt, nn, ff, m5, dac, tag);
        set_pwr(1'b1);
        wait (sb.size() == 0);
    endtask

    // monitor side: pops expected pulses and compares
    bit          pw_seen = 1'b0;
    int unsigned since = 0;
    int unsigned last_comp = 0;
    bit          held_bad = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit sampled;
            sampled = pw_seen;
            if (!sampled) since = 0;
            else since++;
            if (div_pulse) begin
                pulses_seen++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R9", "unexpected pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(since == e.ivl, e.tag, "interval", since, e.ivl);
                    chk(frd_out == e.frd, e.tag, "frd", frd_out, e.frd);
                    chk(comp_out == e.comp, "R8", {e.tag, " comp"}, comp_out, e.comp);
                    chk(comp_strobe == 1'b1, "R8", "strobe", comp_strobe, 1);
                    chk(!held_bad, "R8", "comp held between pulses", held_bad, 0);
                end
                since = 0;
                held_bad = 1'b0;
            end else if (sampled && comp_out != last_comp) begin
                held_bad = 1'b1;
            end
            if (!div_pulse && sampled && comp_strobe) held_bad = 1'b1;
            last_comp = comp_out;
        end
        pw_seen = main_pwr;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned pc0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(div_pulse == 0, "R1", "div_pulse", div_pulse, 0);
        chk(comp_strobe == 0, "R1", "comp_strobe", comp_strobe, 0);
        chk(frd_out == 0, "R1", "frd_out", frd_out, 0);
        chk(comp_out == 0, "R1", "comp_out", comp_out, 0);
        chk(nf_err == 0, "R1", "nf_err", nf_err, 0);

        run_phase(520, 0, 1'b0, 10, 3, "R2", 1'b0);
        run_phase(600, 2, 1'b1, 80, 6, "R3", 1'b0);
        run_phase(530, 3, 1'b0, 128, 9, "R4", 1'b0);
        run_phase(515, 7, 1'b1, 255, 5, "R6", 1'b1);
        run_phase(100, 1, 1'b0, 3, 3, "R7", 1'b0);

        // R5: reload mid-cycle, applied only at the next boundary
        run_phase(540, 5, 1'b0, 7, 2, "R5", 1'b0);
        drive_cfg(700, 1, 1'b1, 9);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(frd_out == m_acc, "R5", "frd before boundary", frd_out, m_acc);
        chk(comp_out == m_acc * 7, "R5", "comp before boundary", comp_out, m_acc * 7);
        push_apply(700, 1, 9, "R5");
        push_steps(3, 700, 1, 1'b1, 9, "R5");
        wait (sb.size() == 0);

        // R9: long idle while powered down
        set_pwr(1'b0);
        pc0 = pulses_seen;
        repeat (1500) @(posedge clk);
        @(negedge clk);
        chk(pulses_seen == pc0, "R9", "pulses while off", pulses_seen - pc0, 0);
        chk(frd_out == 0, "R9", "frd after idle", frd_out, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule